// File: doc/BRIEF.md
# Multichannel Scanned Trigger Combiner

This block turns a stream of digitized samples into a single acquisition trigger. Samples come from a converter sequencer in scan order. Each sample carries a channel index, and an optional start-of-scan marker travels with it. An enable mask picks the channels that take part in triggering. Each enabled channel is compared against its own programmed level, and a per-channel polarity bit chooses whether the sample must be above or below that level. The outcome is recorded as a per-channel flag.

The combining step waits for the whole scan. When the sample of the highest-numbered enabled channel has been evaluated, the recorded flags are merged into one decision. OR mode fires when any enabled channel hit. AND mode fires only when every enabled channel hit. The merge happens only if every enabled channel was actually seen in the current scan. The result leaves as a one-cycle pulse. Two readiness inputs gate the pulse. If the configuration is incomplete, or the previous acquisition is still finishing, the decision is dropped and nothing signals that it was dropped.

A scan starts either when the sample of the lowest enabled channel arrives or when the explicit marker is seen. In both cases the gathered flags are cleared. Evaluating the highest enabled channel closes the scan, so the same flags are never judged twice.

Top module: `scan_trig_combiner`

## Requirements
- R1: A channel hits when its polarity bit is 0 and the unsigned sample is strictly greater than its level, or when its polarity bit is 1 and the sample is strictly less than its level. A sample equal to the level never hits.
- R2: A sample whose channel bit in `en_mask` is 0 changes no scan state and never causes a trigger, unless it carries the start-of-scan marker.
- R3: `trig_out` rises only in the cycle right after a valid sample of the highest-numbered enabled channel.
- R4: No trigger is issued unless every enabled channel has been examined since the current scan began.
- R5: With `comb_all`=0 (OR mode), a complete scan triggers when at least one enabled channel hit.
- R6: With `comb_all`=1 (AND mode), a complete scan triggers only when all enabled channels hit.
- R7: The per-channel flags clear when a valid sample carries `smp_sos`=1, when a valid sample of the lowest enabled channel arrives, and after the highest enabled channel has been evaluated.
- R8: An all-zero `en_mask` never produces a trigger, in either mode.
- R9: If `cfg_ready` or `acq_idle` is 0 in the cycle of the closing sample, the trigger is dropped and that scan cannot trigger later.
- R10: `trig_out` is 0 during reset and is a single-cycle pulse. Consecutive pulses can occur only when one channel is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | A sample is present this cycle |
| smp_sos | input | 1 | Start-of-scan marker, qualified by `smp_valid` |
| smp_chan | input | CH_W | Channel index of the sample |
| smp_data | input | DATA_W | Unsigned sample value |
| lvl_flat | input | NUM_CH*DATA_W | Per-channel levels; channel i at bits [i*DATA_W +: DATA_W] |
| pol_mask | input | NUM_CH | Per-channel polarity: 0 above level, 1 below level |
| en_mask | input | NUM_CH | Channels taking part in triggering |
| comb_all | input | 1 | 0: OR of channel results, 1: AND |
| cfg_ready | input | 1 | Configuration is complete |
| acq_idle | input | 1 | No acquisition is still finishing |
| trig_out | output | 1 | One-cycle trigger pulse |

## Verification
The assertions assume that configuration inputs (`en_mask`, levels, polarity, mode) change only between samples. They also assume that channel indices stay below `NUM_CH`. The bench honours both. It reprograms only in cycles with `smp_valid` low and draws channel numbers from the valid range. Random scans in ascending channel order drop an enabled channel now and then, and sometimes raise the marker or deassert a readiness input. Directed cases cover equality at the level, disabled channels carrying hitting values, marker clears, wrap clears, an empty mask and dropped triggers.

// File: rtl/stc_pkg.sv
// Shared definitions for the scanned trigger combiner.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package stc_pkg;

    // How per-channel results merge into the final decision
    typedef enum logic {
        COMB_ANY = 1'b0,
        COMB_ALL = 1'b1
    } comb_mode_e;

    // Width of an index able to address n items (at least 1 bit)
    function automatic int unsigned idx_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/stc_mask_bounds.sv
// Finds the lowest and highest set bit of the enable mask.
// The lowest marks a scan start and the highest marks the scan close.
// Assumes: purely combinational; outputs are 0 when the mask is empty.
module stc_mask_bounds #(
    parameter int NUM_CH = 8,
    parameter int CH_W   = 3
) (
    input  logic [NUM_CH-1:0] en_mask,
    output logic              any_en,
    output logic [CH_W-1:0]   first_ch,
    output logic [CH_W-1:0]   last_ch
);

    // Scan the mask from both ends to locate the boundary channels
    always_comb begin
        any_en   = |en_mask;
        first_ch = '0;
        last_ch  = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (en_mask[i]) first_ch = CH_W'(i);
        end
        for (int i = 0; i < NUM_CH; i++) begin
            if (en_mask[i]) last_ch = CH_W'(i);
        end
    end

endmodule

// File: rtl/stc_level_cmp.sv
// Compares the current sample against the level of its own channel.
// The polarity bit of that channel selects the direction of the test.
// Assumes: unsigned data; the comparison is strict in both directions.
module stc_level_cmp #(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 12,
    parameter int CH_W   = 3
) (
    input  logic [CH_W-1:0]          chan,
    input  logic [DATA_W-1:0]        data,
    input  logic [NUM_CH*DATA_W-1:0] lvl_flat,
    input  logic [NUM_CH-1:0]        pol_mask,
    output logic                     chan_ok,
    output logic                     hit
);

    logic [DATA_W-1:0] lvl_arr [NUM_CH];
    logic [DATA_W-1:0] sel_lvl;
    logic              sel_pol;

    // Unpack the flat level bus into one word per channel
    for (genvar g = 0; g < NUM_CH; g++) begin : g_unpack
        assign lvl_arr[g] = lvl_flat[g*DATA_W +: DATA_W];
    end

    // Pick the level and polarity that belong to the sample's channel
    always_comb begin
        chan_ok = 1'b0;
        sel_lvl = '0;
        sel_pol = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (chan == CH_W'(i)) begin
                chan_ok = 1'b1;
                sel_lvl = lvl_arr[i];
                sel_pol = pol_mask[i];
            end
        end
    end

    // Apply the strict above/below test selected by the polarity
    always_comb begin
        if (!chan_ok)     hit = 1'b0;
        else if (sel_pol) hit = (data < sel_lvl);
        else              hit = (data > sel_lvl);
    end

endmodule

// File: rtl/stc_scan_track.sv
// Gathers the per-channel "examined" and "hit" flags across one scan.
// Flags clear on a marker, on a sample of the lowest enabled channel,
// and once the highest enabled channel has been evaluated.
// Assumes: configuration is stable while samples of a scan arrive.
module stc_scan_track #(
    parameter int NUM_CH = 8,
    parameter int CH_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic              smp_sos,
    input  logic [CH_W-1:0]   chan,
    input  logic              chan_ok,
    input  logic              hit,
    input  logic [NUM_CH-1:0] en_mask,
    input  logic [CH_W-1:0]   first_ch,
    input  logic [CH_W-1:0]   last_ch,
    output logic [NUM_CH-1:0] seen_nx,
    output logic [NUM_CH-1:0] hit_nx,
    output logic              close
);

    logic [NUM_CH-1:0] seen_q;
    logic [NUM_CH-1:0] hit_q;
    logic [NUM_CH-1:0] chan_oh;
    logic              accept;
    logic              start;

    // One-hot position of the sample's channel, empty if out of range
    always_comb begin
        chan_oh = chan_ok ? (NUM_CH'(1) << chan) : '0;
    end

    // Decide whether this sample is examined, starts a scan or ends one
    always_comb begin
        accept = smp_valid && |(chan_oh & en_mask);
        start  = smp_valid && (smp_sos || (accept && chan == first_ch));
        close  = accept && (chan == last_ch);
    end

    // Flag vectors as they stand once the current sample is included
    always_comb begin
        seen_nx = start ? '0 : seen_q;
        hit_nx  = start ? '0 : hit_q;
        if (accept) begin
            seen_nx = seen_nx | chan_oh;
            if (hit) hit_nx = hit_nx | chan_oh;
        end
    end

    // Hold the flags between samples; empty them once a scan closes
    always_ff @(posedge clk) begin
        if (!rst_n || close) begin
            seen_q <= '0;
            hit_q  <= '0;
        end else begin
            seen_q <= seen_nx;
            hit_q  <= hit_nx;
        end
    end

    // R2: an unmarked sample of a disabled channel leaves the flags alone
    a_r2_disabled_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !smp_sos && !accept) |=> ($stable(seen_q) && $stable(hit_q)));

    // R7: a marker always empties the flags gathered before it
    a_r7_marker_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_sos && !accept) |=> (seen_q == '0));

endmodule

// File: rtl/stc_combine.sv
// Merges the per-channel flags of a closed scan into the trigger pulse.
// The pulse requires a complete scan, the selected AND/OR verdict, a
// non-empty mask and both readiness inputs.
// Assumes: close is high for exactly the closing sample's cycle.
module stc_combine
    import stc_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              close,
    input  logic [NUM_CH-1:0] seen_nx,
    input  logic [NUM_CH-1:0] hit_nx,
    input  logic [NUM_CH-1:0] en_mask,
    input  logic              any_en,
    input  comb_mode_e        mode,
    input  logic              cfg_ready,
    input  logic              acq_idle,
    output logic              trig_q
);

    logic complete;
    logic verdict;
    logic fire;

    // Check that every enabled channel was examined this scan
    always_comb begin
        complete = ((seen_nx & en_mask) == en_mask);
    end

    // Combine enabled channel results with the selected operator
    always_comb begin
        unique case (mode)
            COMB_ALL: verdict = ((hit_nx & en_mask) == en_mask);
            default:  verdict = |(hit_nx & en_mask);
        endcase
    end

    // Gate the verdict by scan closure, completeness and readiness
    always_comb begin
        fire = close && any_en && complete && verdict && cfg_ready && acq_idle;
    end

    // Register the decision as a one-cycle pulse
    always_ff @(posedge clk) begin
        if (!rst_n) trig_q <= 1'b0;
        else        trig_q <= fire;
    end

    // R9: a pulse follows only a cycle in which both readiness inputs were high
    a_r9_ready_gate: assert property (@(posedge clk) disable iff (!rst_n)
        trig_q |-> $past(cfg_ready && acq_idle));

    // R8: a pulse never follows a cycle with an empty mask
    a_r8_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
        trig_q |-> ($past(en_mask) != '0));

endmodule

// File: rtl/scan_trig_combiner.sv
// Top of the multichannel scanned trigger combiner.
// Level compare, scan flag tracking and final merge form a one-register path.
// The pulse appears in the cycle after the closing sample.
// Assumes: samples of a scan arrive in ascending channel order, and
// configuration changes only between samples.
module scan_trig_combiner
    import stc_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 12,
    localparam int CH_W  = idx_w(NUM_CH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_valid,
    input  logic                     smp_sos,
    input  logic [CH_W-1:0]          smp_chan,
    input  logic [DATA_W-1:0]        smp_data,
    input  logic [NUM_CH*DATA_W-1:0] lvl_flat,
    input  logic [NUM_CH-1:0]        pol_mask,
    input  logic [NUM_CH-1:0]        en_mask,
    input  logic                     comb_all,
    input  logic                     cfg_ready,
    input  logic                     acq_idle,
    output logic                     trig_out
);

    logic              any_en;
    logic [CH_W-1:0]   first_ch;
    logic [CH_W-1:0]   last_ch;
    logic              chan_ok;
    logic              hit;
    logic [NUM_CH-1:0] seen_nx;
    logic [NUM_CH-1:0] hit_nx;
    logic              close;
    comb_mode_e        mode;

    // Map the raw mode bit onto the enumerated combine operator
    always_comb begin
        mode = comb_all ? COMB_ALL : COMB_ANY;
    end

    stc_mask_bounds #(.NUM_CH(NUM_CH), .CH_W(CH_W)) bounds_i (
        .en_mask  (en_mask),
        .any_en   (any_en),
        .first_ch (first_ch),
        .last_ch  (last_ch)
    );

    stc_level_cmp #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .CH_W(CH_W)) cmp_i (
        .chan     (smp_chan),
        .data     (smp_data),
        .lvl_flat (lvl_flat),
        .pol_mask (pol_mask),
        .chan_ok  (chan_ok),
        .hit      (hit)
    );

    stc_scan_track #(.NUM_CH(NUM_CH), .CH_W(CH_W)) track_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_sos   (smp_sos),
        .chan      (smp_chan),
        .chan_ok   (chan_ok),
        .hit       (hit),
        .en_mask   (en_mask),
        .first_ch  (first_ch),
        .last_ch   (last_ch),
        .seen_nx   (seen_nx),
        .hit_nx    (hit_nx),
        .close     (close)
    );

    stc_combine #(.NUM_CH(NUM_CH)) comb_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .close     (close),
        .seen_nx   (seen_nx),
        .hit_nx    (hit_nx),
        .en_mask   (en_mask),
        .any_en    (any_en),
        .mode      (mode),
        .cfg_ready (cfg_ready),
        .acq_idle  (acq_idle),
        .trig_q    (trig_out)
    );

    // R3: a pulse follows a valid sample of the highest enabled channel
    a_r3_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        trig_out |-> ($past(smp_valid) && ($past(smp_chan) == $past(last_ch))));

    // R10: back-to-back pulses only when a single channel is enabled
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        trig_out |=> (!trig_out || ($countones($past(en_mask)) <= 1)));

endmodule

// File: tb/scan_trig_combiner_tb.sv
// Self-checking bench: directed corners plus seeded random scans,
// compared each cycle against a model written from the requirements.
module scan_trig_combiner_tb_top;

    localparam int NUM_CH     = 8;
    localparam int DATA_W     = 12;
    localparam int CH_W       = 3;
    localparam int CLK_PERIOD = 10;

    logic                     clk;
    logic                     rst_n;
    logic                     smp_valid;
    logic                     smp_sos;
    logic [CH_W-1:0]          smp_chan;
    logic [DATA_W-1:0]        smp_data;
    logic [NUM_CH*DATA_W-1:0] lvl_flat;
    logic [NUM_CH-1:0]        pol_mask;
    logic [NUM_CH-1:0]        en_mask;
    logic                     comb_all;
    logic                     cfg_ready;
    logic                     acq_idle;
    logic                     trig_out;

    logic [DATA_W-1:0] lvl_a [NUM_CH];
    logic [NUM_CH-1:0] m_seen;
    logic [NUM_CH-1:0] m_hit;
    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    scan_trig_combiner #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_sos(smp_sos),
        .smp_chan(smp_chan), .smp_data(smp_data), .lvl_flat(lvl_flat),
        .pol_mask(pol_mask), .en_mask(en_mask), .comb_all(comb_all),
        .cfg_ready(cfg_ready), .acq_idle(acq_idle), .trig_out(trig_out)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int i = 0; i < NUM_CH; i++) lvl_flat[i*DATA_W +: DATA_W] = lvl_a[i];
    end

    // Level test as stated in R1
    function automatic logic lvl_hit(input int d, input int l, input logic p);
        return p ? (d < l) : (d > l);
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: trig_out=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    task automatic idle();
        @(negedge clk);
        smp_valid = 1'b0;
        smp_sos   = 1'b0;
    endtask

    // Drive one cycle, predict the output, check after the clock edge
    task automatic step(input logic v, input int ch, input int d,
                        input logic sos, input string tag);
        int   first, last;
        logic acc, start, complete, verdict, exp;
        logic [NUM_CH-1:0] ns, nh;
        @(negedge clk);
        smp_valid = v;
        smp_sos   = sos;
        smp_chan  = CH_W'(ch);
        smp_data  = DATA_W'(d);
        first = 0;
        last  = 0;
        for (int i = NUM_CH - 1; i >= 0; i--) if (en_mask[i]) first = i;
        for (int i = 0; i < NUM_CH; i++) if (en_mask[i]) last = i;
        acc   = v && en_mask[ch];
        start = v && (sos || (acc && ch == first));
        ns = start ? '0 : m_seen;
        nh = start ? '0 : m_hit;
        if (acc) begin
            ns[ch] = 1'b1;
            if (lvl_hit(d, int'(lvl_a[ch]), pol_mask[ch])) nh[ch] = 1'b1;
        end
        complete = ((ns & en_mask) == en_mask);
        verdict  = comb_all ? ((nh & en_mask) == en_mask) : |(nh & en_mask);
        exp = acc && (ch == last) && (en_mask != '0) && complete && verdict
              && cfg_ready && acq_idle;
        if (acc && ch == last) begin
            m_seen = '0;
            m_hit  = '0;
        end else begin
            m_seen = ns;
            m_hit  = nh;
        end
        @(posedge clk);
        #(CLK_PERIOD/4);
        check(tag, trig_out, exp);
    endtask

    task automatic set_all_lvl(input int l, input logic [NUM_CH-1:0] pol);
        for (int i = 0; i < NUM_CH; i++) lvl_a[i] = DATA_W'(l);
        pol_mask = pol;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: trig_out=%0b expected=finished", trig_out);
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        rst_n = 1'b0; smp_valid = 1'b0; smp_sos = 1'b0; smp_chan = '0;
        smp_data = '0; en_mask = '0; comb_all = 1'b0; cfg_ready = 1'b1;
        acq_idle = 1'b1; m_seen = '0; m_hit = '0;
        set_all_lvl(500, '0);
        repeat (3) @(negedge clk);
        check("R10 reset", trig_out, 1'b0);
        rst_n = 1'b1;

        // R1: strict compare in both polarities
        idle(); en_mask = 8'b0000_0100; lvl_a[2] = 100; pol_mask = '0;
        step(1, 2, 100, 0, "R1 equal above");
        step(1, 2, 101, 0, "R1 above");
        idle(); pol_mask = 8'b0000_0100;
        step(1, 2, 100, 0, "R1 equal below");
        step(1, 2, 99, 0, "R1 below");
        step(0, 0, 0, 0, "R10 pulse ends");

        // R5: OR mode
        idle(); en_mask = 8'b0000_0111; set_all_lvl(500, '0); comb_all = 0;
        step(1, 0, 10, 0, "R5"); step(1, 1, 600, 0, "R5"); step(1, 2, 10, 0, "R5 one hit");
        step(1, 0, 10, 0, "R5"); step(1, 1, 10, 0, "R5"); step(1, 2, 10, 0, "R5 no hit");

        // R6: AND mode
        idle(); comb_all = 1;
        step(1, 0, 600, 0, "R6"); step(1, 1, 600, 0, "R6"); step(1, 2, 10, 0, "R6 partial");
        step(1, 0, 600, 0, "R6"); step(1, 1, 600, 0, "R6"); step(1, 2, 600, 0, "R6 all");

        // R2: disabled channels with hitting values are ignored
        idle(); comb_all = 0; en_mask = 8'b0000_0101;
        step(1, 0, 10, 0, "R2"); step(1, 1, 4000, 0, "R2 disabled mid");
        step(1, 2, 10, 0, "R2 no hit"); step(1, 3, 4000, 0, "R2 disabled after");

        // R4: a skipped enabled channel blocks the trigger
        idle(); en_mask = 8'b0000_0111;
        step(1, 0, 600, 0, "R4"); step(1, 2, 600, 0, "R4 missing ch1");

        // R7: marker and wrap clear the flags
        idle(); en_mask = 8'b0000_0110;
        step(1, 1, 600, 0, "R7"); step(1, 5, 10, 1, "R7 marker");
        step(1, 2, 10, 0, "R7 cleared by marker");
        step(1, 1, 10, 0, "R7"); step(1, 2, 600, 0, "R7 new scan");
        step(1, 1, 600, 0, "R7"); step(1, 1, 10, 0, "R7 wrap");
        step(1, 2, 10, 0, "R7 cleared by wrap");

        // R8: empty mask
        idle(); en_mask = '0;
        for (int c = 0; c < NUM_CH; c++) step(1, c, 4000, c == 0, "R8");
        idle(); comb_all = 1;
        for (int c = 0; c < NUM_CH; c++) step(1, c, 4000, 0, "R8 and");

        // R9: readiness drops the trigger and closes the scan
        idle(); comb_all = 0; en_mask = 8'b0000_0110; cfg_ready = 0;
        step(1, 1, 600, 0, "R9"); step(1, 2, 600, 0, "R9 cfg not ready");
        idle(); cfg_ready = 1;
        step(1, 2, 600, 0, "R9 scan closed");
        idle(); acq_idle = 0;
        step(1, 1, 600, 0, "R9"); step(1, 2, 600, 0, "R9 busy");
        idle(); acq_idle = 1;
        step(1, 1, 600, 0, "R3"); step(1, 2, 600, 0, "R3 fires after last");
        step(0, 0, 0, 0, "R10 single");

        // Random scans in ascending order
        for (int s = 0; s < 400; s++) begin
            idle();
            en_mask   = NUM_CH'($urandom);
            if ($urandom % 16 == 0) en_mask = '0;
            comb_all  = 1'($urandom % 2);
            pol_mask  = comb_all ? '0 : NUM_CH'($urandom);
            for (int c = 0; c < NUM_CH; c++)
                lvl_a[c] = comb_all ? DATA_W'($urandom % 512) : DATA_W'($urandom);
            cfg_ready = ($urandom % 8) != 0;
            acq_idle  = ($urandom % 8) != 0;
            for (int c = 0; c < NUM_CH; c++) begin
                if ($urandom % 10 == 0) continue;
                step(1, c, int'($urandom % 4096), (c == 0) && ($urandom % 2 == 1),
                     comb_all ? "R6 random" : "R5 random");
            end
            if ($urandom % 3 == 0) step(0, 0, 0, 0, "R10 random gap");
        end

        finish_run();
    end

endmodule